// File: doc/BRIEF.md
# Linked-List Descriptor Fetch Engine

This block is the sequencing core of one DMA channel. Software builds a chain of block descriptors in memory and hands the engine the address of the first one. For each descriptor the engine reads the address and control words over a simple one-beat-at-a-time read port, then runs a placeholder block transfer that only counts the block size down to zero. It then posts the control-high word back into the descriptor with its done flag set and moves on to the next descriptor through the link field.

Each descriptor record is 64-bit-address based. The record holds a source address, a destination address and a link address, then a control-low word and a control-high word. The engine fetches only these eight 32-bit words; the two status words behind them are not read. A chain stops on a zero link, or when either chaining-enable bit of the block is clear. The live link register and the remaining-count register are brought out so that software can work out how many bytes are left. A transfer-complete event marks the end of a chain whose final block asked for an interrupt. An error event marks a descriptor address that is not 8-byte aligned.

Top module: `lldFetchEngine`

## Requirements
- R1: After reset the engine is idle (busy low), curPtr and remCount are 0, and no read, write or event output is active.
- R2: A start pulse with an 8-byte-aligned head pointer makes the engine issue exactly eight read requests, at head+0x00 through head+0x1C in steps of 4 and in that order. It never has more than one request outstanding, and each request lasts one cycle.
- R3: The fetched words map as follows. Words 0 and 1 are the source address, low half first, and appear on curSrc. Words 2 and 3 are the destination address and appear on curDst. Words 4 and 5 are the link address and appear on curPtr. Word 6 is control-low and appears on curCtlLo. Word 7 is control-high, whose bits 16:0 are the block size.
- R4: remCount loads the block size from control-high bits 16:0 and then drops by exactly one per cycle until it reaches 0. A size of 0 spends no countdown cycles.
- R5: When the countdown ends, the engine writes the fetched control-high word back to the descriptor address + 0x1C with bit 17 set and all other bits unchanged. The write lasts one cycle, and blockDone pulses in that same cycle.
- R6: After the write-back the engine fetches the descriptor at the link address when that address is nonzero and control-low bits 27 and 28 are both 1.
- R7: The chain ends, and busy drops, when the link address is 0 or when control-low bit 27 or bit 28 is 0.
- R8: xferDone pulses, together with the last blockDone of a chain, only when that last block has control-low bit 0 set. Bit 0 on a block that is not the last has no effect.
- R9: A start pulse whose head pointer has any of bits 2:0 set raises errEvt for one cycle, issues no read and leaves the engine idle.
- R10: A link address that passes the chaining test but is not 8-byte aligned raises errEvt after that block's write-back, and the engine halts with no further reads.
- R11: A start pulse while the engine is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking a chain at headPtr |
| headPtr | input | 64 | Address of the first descriptor |
| rdReq | output | 1 | Read request, one cycle per beat |
| rdAddr | output | 64 | Read address |
| rdValid | input | 1 | Read data valid |
| rdData | input | 32 | Read data beat |
| wrEn | output | 1 | Write-back strobe |
| wrAddr | output | 64 | Write-back address |
| wrData | output | 32 | Write-back data (control-high with done flag) |
| busy | output | 1 | Chain in progress |
| curPtr | output | 64 | Live link-pointer register |
| remCount | output | 17 | Live remaining block count |
| curSrc | output | 64 | Source address of current block |
| curDst | output | 64 | Destination address of current block |
| curCtlLo | output | 32 | Control-low word of current block |
| blockDone | output | 1 | Block-complete event pulse |
| xferDone | output | 1 | Transfer-complete event pulse |
| errEvt | output | 1 | Misaligned-descriptor error pulse |

## Verification
The assertions take it for granted that the memory side returns exactly one rdValid beat for each request. They also assume that beat comes only while the engine waits for it, and that data for a descriptor is stable in memory for the whole walk. The bench memory model answers each request with one beat a fixed two cycles later. It accepts no new request until the previous beat has been delivered, and every descriptor is rewritten before the chain that uses it starts. Stray start pulses are driven only while the engine is busy, so the ignored case is exercised without breaking these assumptions.

// File: rtl/lldPkg.sv
package lldPkg;
  localparam int ADDR_W   = 64;
  localparam int WORD_W   = 32;
  localparam int SIZE_W   = 17;
  localparam int BEATS    = 8;
  localparam int BEAT_W   = $clog2(BEATS);
  localparam int ALIGN_W  = 3;
  localparam int DONE_BIT = 17;
  localparam int INT_BIT  = 0;
  localparam int CHAIN_D  = 27;
  localparam int CHAIN_S  = 28;
  localparam logic [ADDR_W-1:0] CTLHI_OFS = 64'h1C;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_XFER, ST_WBACK
  } stateT;

  typedef struct packed {
    logic loadHead;
    logic followNext;
    logic capture;
    logic countDown;
  } strobeT;
endpackage

// File: rtl/lldDpath.sv
module lldDpath
  import lldPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] headPtr,
  input  logic [WORD_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic [ADDR_W-1:0] curPtr,
  output logic [SIZE_W-1:0] remCount,
  output logic [ADDR_W-1:0] curSrc,
  output logic [ADDR_W-1:0] curDst,
  output logic [WORD_W-1:0] curCtlLo,
  output logic              lastBeat,
  output logic              countZero,
  output logic              chainGo,
  output logic              nextAligned,
  output logic              headAligned,
  output logic              intEn
);
  logic [ADDR_W-1:0] descAddr;
  logic [BEAT_W-1:0] beatIdx;
  logic [ADDR_W-1:0] srcR, dstR, llpR;
  logic [WORD_W-1:0] ctlLoR, ctlHiR;
  logic [SIZE_W-1:0] remR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr <= '0;
      beatIdx  <= '0;
      srcR     <= '0;
      dstR     <= '0;
      llpR     <= '0;
      ctlLoR   <= '0;
      ctlHiR   <= '0;
      remR     <= '0;
    end else begin
      if (stb.loadHead) begin
        descAddr <= headPtr;
        llpR     <= headPtr;
        beatIdx  <= '0;
      end else if (stb.followNext) begin
        descAddr <= llpR;
        beatIdx  <= '0;
      end else if (stb.capture) begin
        beatIdx <= beatIdx + 1'b1;
        case (beatIdx)
          3'd0: srcR[31:0]  <= rdData;
          3'd1: srcR[63:32] <= rdData;
          3'd2: dstR[31:0]  <= rdData;
          3'd3: dstR[63:32] <= rdData;
          3'd4: llpR[31:0]  <= rdData;
          3'd5: llpR[63:32] <= rdData;
          3'd6: ctlLoR      <= rdData;
          default: begin
            ctlHiR <= rdData;
            remR   <= rdData[SIZE_W-1:0];
          end
        endcase
      end
      if (stb.countDown) remR <= remR - 1'b1;
    end
  end

  assign rdAddr      = descAddr + {{(ADDR_W-BEAT_W-2){1'b0}}, beatIdx, 2'b00};
  assign wrAddr      = descAddr + CTLHI_OFS;
  assign wrData      = ctlHiR | (WORD_W'(1) << DONE_BIT);
  assign curPtr      = llpR;
  assign remCount    = remR;
  assign curSrc      = srcR;
  assign curDst      = dstR;
  assign curCtlLo    = ctlLoR;
  assign lastBeat    = (beatIdx == BEAT_W'(BEATS-1));
  assign countZero   = (remR == '0);
  assign chainGo     = (llpR != '0) && ctlLoR[CHAIN_D] && ctlLoR[CHAIN_S];
  assign nextAligned = (llpR[ALIGN_W-1:0] == '0);
  assign headAligned = (headPtr[ALIGN_W-1:0] == '0);
  assign intEn       = ctlLoR[INT_BIT];

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.countDown |=> (remCount == $past(remCount) - 1'b1));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.countDown && !stb.capture) |=> $stable(remCount));
endmodule

// File: rtl/lldCtrl.sv
module lldCtrl
  import lldPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   rdValid,
  input  logic   lastBeat,
  input  logic   countZero,
  input  logic   chainGo,
  input  logic   nextAligned,
  input  logic   headAligned,
  input  logic   intEn,
  output strobeT stb,
  output logic   rdReq,
  output logic   wrEn,
  output logic   blockDone,
  output logic   xferDone,
  output logic   errEvt,
  output logic   busy
);
  stateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    rdReq     = 1'b0;
    wrEn      = 1'b0;
    blockDone = 1'b0;
    xferDone  = 1'b0;
    errEvt    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (headAligned) begin
            stb.loadHead = 1'b1;
            nextState    = ST_FETCH;
          end else begin
            errEvt = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        rdReq     = 1'b1;
        nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (rdValid) begin
          stb.capture = 1'b1;
          nextState   = lastBeat ? ST_XFER : ST_FETCH;
        end
      end
      ST_XFER: begin
        if (countZero) nextState = ST_WBACK;
        else           stb.countDown = 1'b1;
      end
      ST_WBACK: begin
        wrEn      = 1'b1;
        blockDone = 1'b1;
        if (chainGo) begin
          if (nextAligned) begin
            stb.followNext = 1'b1;
            nextState      = ST_FETCH;
          end else begin
            errEvt    = 1'b1;
            nextState = ST_IDLE;
          end
        end else begin
          xferDone  = intEn;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R2
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R5
  wb_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R8
  xfer_with_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> blockDone);

  // R10
  err_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    errEvt |=> !busy);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !blockDone) |=> busy);
endmodule

// File: rtl/lldFetchEngine.sv
module lldFetchEngine
  import lldPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] headPtr,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [WORD_W-1:0] rdData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              busy,
  output logic [ADDR_W-1:0] curPtr,
  output logic [SIZE_W-1:0] remCount,
  output logic [ADDR_W-1:0] curSrc,
  output logic [ADDR_W-1:0] curDst,
  output logic [WORD_W-1:0] curCtlLo,
  output logic              blockDone,
  output logic              xferDone,
  output logic              errEvt
);
  strobeT stb;
  logic lastBeat, countZero, chainGo, nextAligned, headAligned, intEn;

  lldCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .rdValid(rdValid),
    .lastBeat(lastBeat), .countZero(countZero), .chainGo(chainGo),
    .nextAligned(nextAligned), .headAligned(headAligned), .intEn(intEn),
    .stb(stb), .rdReq(rdReq), .wrEn(wrEn), .blockDone(blockDone),
    .xferDone(xferDone), .errEvt(errEvt), .busy(busy)
  );

  lldDpath uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .headPtr(headPtr), .rdData(rdData),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrData(wrData), .curPtr(curPtr),
    .remCount(remCount), .curSrc(curSrc), .curDst(curDst),
    .curCtlLo(curCtlLo), .lastBeat(lastBeat), .countZero(countZero),
    .chainGo(chainGo), .nextAligned(nextAligned),
    .headAligned(headAligned), .intEn(intEn)
  );

  // R5
  done_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrData[DONE_BIT]);

  // R9
  err_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errEvt && !blockDone) |-> !rdReq);
endmodule

// File: tb/tb_lldFetchEngine.sv
module tb_lldFetchEngine;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CHAIN = 32'h1800_0000;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [63:0] headPtr = '0;
  logic rdReq, rdValid, wrEn, busy, blockDone, xferDone, errEvt;
  logic [63:0] rdAddr, wrAddr, curPtr, curSrc, curDst;
  logic [31:0] rdData, wrData, curCtlLo;
  logic [16:0] remCount;

  lldFetchEngine dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [0:255];
  logic [1:0]  pend;
  logic [9:0]  pendAddr;
  int rdCnt = 0, blkCnt = 0, xferCnt = 0, errCnt = 0, stepBad = 0;
  int peakRem = 0, prevRem = 0;
  logic [63:0] rdLog [0:511];
  logic [63:0] ptrLog [0:511];
  logic [63:0] wrALog [0:511];
  logic [31:0] wrDLog [0:511];
  int checks = 0, errors = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0; pend <= '0; rdData <= '0; pendAddr <= '0;
    end else begin
      rdValid <= 1'b0;
      if (pend == 2'd1) begin rdValid <= 1'b1; rdData <= mem[pendAddr[9:2]]; end
      if (pend != 2'd0) pend <= pend - 2'd1;
      if (rdReq) begin
        pend <= 2'd2; pendAddr <= rdAddr[9:0];
        rdLog[rdCnt[8:0]] = rdAddr; rdCnt++;
      end
      if (wrEn) mem[wrAddr[9:2]] = wrData;
      if (blockDone) begin
        ptrLog[blkCnt[8:0]] = curPtr; wrALog[blkCnt[8:0]] = wrAddr;
        wrDLog[blkCnt[8:0]] = wrData; blkCnt++;
      end
      if (xferDone) xferCnt++;
      if (errEvt) errCnt++;
      if (int'(remCount) != prevRem && prevRem != 0 && int'(remCount) != prevRem - 1) stepBad++;
      if (int'(remCount) > peakRem) peakRem = int'(remCount);
      prevRem = int'(remCount);
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setDesc(input int base, input logic [63:0] src, input logic [63:0] dst,
                         input logic [63:0] nxt, input logic [31:0] lo, input logic [31:0] hi);
    mem[(base>>2)+0] = src[31:0]; mem[(base>>2)+1] = src[63:32];
    mem[(base>>2)+2] = dst[31:0]; mem[(base>>2)+3] = dst[63:32];
    mem[(base>>2)+4] = nxt[31:0]; mem[(base>>2)+5] = nxt[63:32];
    mem[(base>>2)+6] = lo;        mem[(base>>2)+7] = hi;
  endtask

  task automatic pulseStart(input logic [63:0] head);
    @(negedge clk); start = 1'b1; headPtr = head;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 3000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    if (busy) begin errors++; $display("FAIL timeout: engine still busy"); end
  endtask

  task automatic tReset();
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 curPtr", curPtr, 64'd0);
    check("R1 remCount", 64'(remCount), 64'd0);
    check("R1 rdReq", 64'(rdReq), 64'd0);
    check("R1 events", 64'({wrEn, blockDone, xferDone, errEvt}), 64'd0);
  endtask

  task automatic tSingle();
    int r0 = rdCnt, b0 = blkCnt, x0 = xferCnt;
    setDesc(32'h40, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'd0,
            CHAIN | 32'h0000_0025, 32'hABC0_0005);
    peakRem = 0; stepBad = 0;
    pulseStart(64'h40);
    waitIdle();
    check("R2 read count", 64'(rdCnt - r0), 64'd8);
    for (int i = 0; i < 8; i++) check("R2 read order", rdLog[(r0+i) & 511], 64'h40 + 64'(4*i));
    check("R3 src", curSrc, 64'h1111_2222_3333_4444);
    check("R3 dst", curDst, 64'h5555_6666_7777_8888);
    check("R3 ctlLo", 64'(curCtlLo), 64'(CHAIN | 32'h25));
    check("R4 peak", 64'(peakRem), 64'd5);
    check("R4 step", 64'(stepBad), 64'd0);
    check("R4 end zero", 64'(remCount), 64'd0);
    check("R5 blocks", 64'(blkCnt - b0), 64'd1);
    check("R5 wb addr", wrALog[b0 & 511], 64'h5C);
    check("R5 wb data", 64'(wrDLog[b0 & 511]), 64'hABC2_0005);
    check("R5 mem", 64'(mem[32'h5C >> 2]), 64'hABC2_0005);
    check("R7 curPtr", curPtr, 64'd0);
    check("R8 xfer", 64'(xferCnt - x0), 64'd1);
  endtask

  task automatic tChain3();
    int r0 = rdCnt, b0 = blkCnt, x0 = xferCnt;
    setDesc(32'h80,  64'hA, 64'hB, 64'hC0,  CHAIN | 32'h1, 32'h0000_0003);
    setDesc(32'hC0,  64'hC, 64'hD, 64'h100, CHAIN,         32'hABC0_0000);
    setDesc(32'h100, 64'hE, 64'hF, 64'd0,   CHAIN | 32'h1, 32'h0000_0004);
    stepBad = 0;
    pulseStart(64'h80);
    waitIdle();
    check("R6 reads", 64'(rdCnt - r0), 64'd24);
    check("R6 blocks", 64'(blkCnt - b0), 64'd3);
    check("R6 ptr0", ptrLog[b0 & 511], 64'hC0);
    check("R6 ptr1", ptrLog[(b0+1) & 511], 64'h100);
    check("R7 ptr2", ptrLog[(b0+2) & 511], 64'd0);
    check("R6 wb0", wrALog[b0 & 511], 64'h9C);
    check("R6 wb1", wrALog[(b0+1) & 511], 64'hDC);
    check("R6 wb2", wrALog[(b0+2) & 511], 64'h11C);
    check("R6 third fetch", rdLog[(r0+16) & 511], 64'h100);
    check("R4 size zero wb", 64'(wrDLog[(b0+1) & 511]), 64'hABC2_0000);
    check("R4 step chain", 64'(stepBad), 64'd0);
    check("R8 one xfer", 64'(xferCnt - x0), 64'd1);
  endtask

  task automatic tNoInt();
    int b0 = blkCnt, x0 = xferCnt;
    setDesc(32'h40, 64'h1, 64'h2, 64'd0, CHAIN, 32'h0000_0002);
    pulseStart(64'h40);
    waitIdle();
    check("R8 no int blocks", 64'(blkCnt - b0), 64'd1);
    check("R8 no int xfer", 64'(xferCnt - x0), 64'd0);
  endtask

  task automatic tChainBit();
    int r0 = rdCnt, b0 = blkCnt;
    setDesc(32'h40, 64'h1, 64'h2, 64'h80, 32'h0800_0001, 32'h0000_0001);
    setDesc(32'h80, 64'h3, 64'h4, 64'd0,  CHAIN, 32'h0000_0001);
    pulseStart(64'h40);
    waitIdle();
    check("R7 chain bit blocks", 64'(blkCnt - b0), 64'd1);
    check("R7 chain bit reads", 64'(rdCnt - r0), 64'd8);
    check("R7 busy", 64'(busy), 64'd0);
  endtask

  task automatic tBadHead();
    int r0 = rdCnt, e0 = errCnt;
    pulseStart(64'h44);
    waitIdle();
    check("R9 err", 64'(errCnt - e0), 64'd1);
    check("R9 no read", 64'(rdCnt - r0), 64'd0);
    check("R9 idle", 64'(busy), 64'd0);
  endtask

  task automatic tBadNext();
    int r0 = rdCnt, b0 = blkCnt, e0 = errCnt, x0 = xferCnt;
    setDesc(32'h40, 64'h1, 64'h2, 64'hC4, CHAIN | 32'h1, 32'h0000_0002);
    pulseStart(64'h40);
    waitIdle();
    check("R10 blocks", 64'(blkCnt - b0), 64'd1);
    check("R10 err", 64'(errCnt - e0), 64'd1);
    check("R10 reads", 64'(rdCnt - r0), 64'd8);
    check("R10 xfer", 64'(xferCnt - x0), 64'd0);
    check("R10 halted", 64'(busy), 64'd0);
  endtask

  task automatic tBusyStart();
    int r0 = rdCnt, b0 = blkCnt;
    setDesc(32'h40, 64'h1, 64'h2, 64'd0, CHAIN | 32'h1, 32'h0000_0014);
    setDesc(32'h80, 64'h3, 64'h4, 64'd0, CHAIN | 32'h1, 32'h0000_0001);
    pulseStart(64'h40);
    repeat (5) @(negedge clk);
    pulseStart(64'h80);
    repeat (30) @(negedge clk);
    pulseStart(64'h80);
    waitIdle();
    check("R11 reads", 64'(rdCnt - r0), 64'd8);
    check("R11 first addr", rdLog[r0 & 511], 64'h40);
    check("R11 blocks", 64'(blkCnt - b0), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSingle();
    tChain3();
    tNoInt();
    tChainBit();
    tBadHead();
    tBadNext();
    tBusyStart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule